// File: doc/BRIEF.md
# Select-Pin Programmable Clock Divider

This block takes a single input clock and a 4-bit select code. It produces three clock outputs: a divided clock, the exact complement of that clock, and a slower clock that runs at half the rate of the divided clock. The divide ratio is chosen from a fixed decode of the select code. The available ratios are 1, 2, 3, 4, 5, 6 and 8. Several codes stop the block entirely, and in that state every output is held low.

For odd ratios, the high phase is stretched by half an input period with a falling-edge copy, so the duty cycle stays at 50%. The half-rate clock is taken from the same counter as the main clock, and its rising edges coincide with rising edges of the main clock. A change of select code restarts the counting from zero on the next rising input edge.

An output enable drives all three clock outputs. When the enable is low, the three outputs float. A separate flag marks the one select code that asks for frequency multiplication, which this block does not support. That code runs at ratio 1 instead.

Top module: `selclk_divider`

## Requirements
- R1: Any select code whose bits [1:0] are 00 powers the block down: clk_main, clk_main_n and clk_half are all held low.
- R2: With sel[3:2]=11, sel[1:0]=01 gives ratio 6, 10 gives ratio 8, and 11 gives ratio 2.
- R3: With sel[3:2]=00 or 10, sel[1:0]=01 gives ratio 4, 10 gives ratio 1, and 11 gives ratio 2.
- R4: With sel[3:2]=01, sel[1:0]=10 gives ratio 5 and 11 gives ratio 3. Code 0101 runs at ratio 1 with sel_unsupported high. No other code raises sel_unsupported.
- R5: For a ratio N, clk_half has a period of 2N input periods and a high time of N input periods. Each of its rising edges coincides with a rising edge of clk_main.
- R6: For a ratio N, clk_main has a period of N input periods and a high time of exactly N half input periods, for odd N as well as even N.
- R7: While the block is active and enabled, clk_main_n is the complement of clk_main.
- R8: When oe is low, clk_main, clk_main_n and clk_half are all high-impedance.
- R9: The select code is sampled on the rising input edge. After a change of code, the first rising edge restarts the count, so clk_main and clk_half both go high. The following high pulse of clk_main has its full length.
- R10: rst_n is synchronous and active low. After a rising edge with rst_n low, all three clock outputs are low and sel_unsupported is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 4 | Select code for ratio and power-down |
| oe | input | 1 | Output enable; low floats the three clock outputs |
| clk_main | output | 1 | Divided clock |
| clk_main_n | output | 1 | Complement of the divided clock |
| clk_half | output | 1 | Clock at half the rate of clk_main |
| sel_unsupported | output | 1 | High while the multiplication code is selected |

## Verification
The hardest case to reach from the ports is a code change that lands in the low phase of a long ratio. Without the restart, this is where a runt pulse would appear. To reach it, the bench runs at ratio 8 and waits for the falling edge of clk_main. It then moves the code to ratio 6 on the next falling input edge. On the following rising edge, it checks that both clocks rise, and it measures the full length of the next high pulse. The odd-ratio duty cycle is also checked directly: every code in the sweep is timed edge to edge in simulation time, and the high time is compared with N half periods.

// File: rtl/selclk_pkg.sv
`timescale 1ns/1ps
// selclk_pkg: shared widths and the select-code decode for the divider.
// Assumes the select code is 4 bits and that the largest ratio is a power of two.
package selclk_pkg;

    localparam int SEL_W      = 4;
    localparam int MAX_RATIO  = 8;
    localparam int RATIO_W    = $clog2(MAX_RATIO + 1);
    localparam int CNT_W      = $clog2(MAX_RATIO);
    localparam logic [SEL_W-1:0] UNSUP_CODE = 4'b0101;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [CNT_W-1:0]   cnt_t;

    // Map a select code to its divide ratio; zero stands for power-down.
    function automatic ratio_t decode_ratio(input logic [SEL_W-1:0] code);
        ratio_t r;
        r = '0;
        if (code[1:0] != 2'b00) begin
            case (code[3:2])
                2'b11: begin
                    case (code[1:0])
                        2'b01:   r = ratio_t'(6);
                        2'b10:   r = ratio_t'(8);
                        default: r = ratio_t'(2);
                    endcase
                end
                2'b01: begin
                    case (code[1:0])
                        2'b01:   r = ratio_t'(1);
                        2'b10:   r = ratio_t'(5);
                        default: r = ratio_t'(3);
                    endcase
                end
                default: begin
                    case (code[1:0])
                        2'b01:   r = ratio_t'(4);
                        2'b10:   r = ratio_t'(1);
                        default: r = ratio_t'(2);
                    endcase
                end
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/selclk_decode.sv
`timescale 1ns/1ps
// selclk_decode: samples the select code, decodes the ratio, and flags a code change.
// Assumes sel may change at any time; it is used only after one register stage.
module selclk_decode
    import selclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output ratio_t           ratio,
    output logic             restart,
    output logic             active,
    output logic             unsupported
);

    logic [SEL_W-1:0] sel_q;
    logic             run_q;

    // Capture the select code on every rising edge, reset included.
    always_ff @(posedge clk) begin
        sel_q <= sel;
    end

    // Track whether reset has been released.
    always_ff @(posedge clk) begin
        if (!rst_n) run_q <= 1'b0;
        else        run_q <= 1'b1;
    end

    // Decode the sampled code and derive the control flags.
    always_comb begin
        ratio       = decode_ratio(sel_q);
        restart     = (sel != sel_q);
        active      = run_q && (ratio != '0);
        unsupported = run_q && (sel_q == UNSUP_CODE);
    end

    // R2 R3 R4: only the listed ratios (or zero) ever appear.
    a_r4_ratio_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd8}));

endmodule

// File: rtl/selclk_counter.sv
`timescale 1ns/1ps
// selclk_counter: counts modulo the ratio and toggles a lap bit at each wrap.
// It also produces the rising-edge phase and a copy retimed on the falling edge.
// Assumes the ratio is stable except on cycles where restart is high.
module selclk_counter
    import selclk_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  ratio_t ratio,
    input  logic   restart,
    output cnt_t   cnt,
    output logic   lap,
    output logic   phase,
    output logic   phase_n
);

    logic   last;
    ratio_t thr;

    // Find the wrap point and the high-phase threshold (floor of ratio/2).
    always_comb begin
        thr   = ratio >> 1;
        last  = ({1'b0, cnt} == ratio_t'(ratio - ratio_t'(1)));
        phase = ({1'b0, cnt} < thr);
    end

    // Count modulo the ratio; restart from zero on reset or a code change.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) begin
            cnt <= '0;
            lap <= 1'b0;
        end else if (ratio != '0) begin
            if (last) begin
                cnt <= '0;
                lap <= ~lap;
            end else begin
                cnt <= cnt + cnt_t'(1);
            end
        end
    end

    // Retime the phase on the falling edge to stretch odd-ratio high times.
    always_ff @(negedge clk) begin
        if (!rst_n) phase_n <= 1'b0;
        else        phase_n <= phase;
    end

    // R6: the count stays below the active ratio.
    a_r6_cnt_below_ratio: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != '0) |-> ({1'b0, cnt} < ratio));

    // R9: a code change restarts the count and the lap.
    a_r9_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0 && !lap));

    // R5: the lap bit flips at every wrap.
    a_r5_half_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && ratio != '0 && {1'b0, cnt} == ratio_t'(ratio - ratio_t'(1)))
        |=> (lap != $past(lap)));

    // R5: the lap bit holds between wraps.
    a_r5_half_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && (ratio == '0 || {1'b0, cnt} != ratio_t'(ratio - ratio_t'(1))))
        |=> $stable(lap));

endmodule

// File: rtl/selclk_outstage.sv
`timescale 1ns/1ps
// selclk_outstage: forms the three clock levels from the counter phases and drives the outputs.
// Assumes ratio 1 passes the input clock through, gated by active.
module selclk_outstage
    import selclk_pkg::*;
(
    input  logic   clk,
    input  logic   oe,
    input  logic   active,
    input  ratio_t ratio,
    input  logic   phase,
    input  logic   phase_n,
    input  logic   lap,
    output logic   clk_main,
    output logic   clk_main_n,
    output logic   clk_half
);

    localparam int NOUT = 3;

    logic            odd;
    logic            main_raw;
    logic [NOUT-1:0] lvl;

    // Choose the main waveform: pass-through, odd stretch, or plain phase.
    always_comb begin
        odd = ratio[0] && (ratio != ratio_t'(1));
        if (ratio == ratio_t'(1)) main_raw = clk;
        else if (odd)             main_raw = phase | phase_n;
        else                      main_raw = phase;
        lvl[0] = active & main_raw;
        lvl[1] = active & ~main_raw;
        lvl[2] = active & ~lap;
    end

    wire [NOUT-1:0] pad;

    // One tri-state driver per clock output.
    for (genvar i = 0; i < NOUT; i++) begin : g_drv
        assign pad[i] = oe ? lvl[i] : 1'bz;
    end

    assign clk_main   = pad[0];
    assign clk_main_n = pad[1];
    assign clk_half   = pad[2];

endmodule

// File: rtl/selclk_divider.sv
`timescale 1ns/1ps
// selclk_divider: top level of the select-programmable clock divider.
// Assumes one input clock; sel and oe may change at any time, and rst_n is synchronous.
module selclk_divider
    import selclk_pkg::*;
(
    input  logic             clk_in,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    input  logic             oe,
    output logic             clk_main,
    output logic             clk_main_n,
    output logic             clk_half,
    output logic             sel_unsupported
);

    ratio_t ratio;
    logic   restart;
    logic   active;
    cnt_t   cnt;
    logic   lap;
    logic   phase;
    logic   phase_n;

    selclk_decode u_decode (
        .clk         (clk_in),
        .rst_n       (rst_n),
        .sel         (sel),
        .ratio       (ratio),
        .restart     (restart),
        .active      (active),
        .unsupported (sel_unsupported)
    );

    selclk_counter u_counter (
        .clk     (clk_in),
        .rst_n   (rst_n),
        .ratio   (ratio),
        .restart (restart),
        .cnt     (cnt),
        .lap     (lap),
        .phase   (phase),
        .phase_n (phase_n)
    );

    selclk_outstage u_out (
        .clk        (clk_in),
        .oe         (oe),
        .active     (active),
        .ratio      (ratio),
        .phase      (phase),
        .phase_n    (phase_n),
        .lap        (lap),
        .clk_main   (clk_main),
        .clk_main_n (clk_main_n),
        .clk_half   (clk_half)
    );

endmodule

// File: tb/selclk_divider_tb.sv
`timescale 1ns/1ps
module selclk_divider_tb;

    logic       clk_in = 1'b0;
    logic       rst_n  = 1'b0;
    logic [3:0] sel    = 4'b0011;
    logic       oe     = 1'b1;
    wire        clk_main, clk_main_n, clk_half, sel_unsupported;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    selclk_divider u_dut (
        .clk_in          (clk_in),
        .rst_n           (rst_n),
        .sel             (sel),
        .oe              (oe),
        .clk_main        (clk_main),
        .clk_main_n      (clk_main_n),
        .clk_half        (clk_half),
        .sel_unsupported (sel_unsupported)
    );

    always #10 clk_in = ~clk_in;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected ratio from R1..R4, zero means power-down.
    function automatic int exp_ratio(input logic [3:0] c);
        if (c[1:0] == 2'b00) return 0;
        if (c[3:2] == 2'b11) return (c[1:0] == 2'b01) ? 6 : (c[1:0] == 2'b10) ? 8 : 2;
        if (c[3:2] == 2'b01) return (c[1:0] == 2'b01) ? 1 : (c[1:0] == 2'b10) ? 5 : 3;
        return (c[1:0] == 2'b01) ? 4 : (c[1:0] == 2'b10) ? 1 : 2;
    endfunction

    function automatic string fam(input logic [3:0] c);
        if (c[1:0] == 2'b00) return "R1";
        if (c[3:2] == 2'b11) return "R2";
        if (c[3:2] == 2'b01) return "R4";
        return "R3";
    endfunction

    task automatic sweep_code(input logic [3:0] c);
        int n;
        realtime t0, t1, t2;
        int bad;
        n = exp_ratio(c);
        @(negedge clk_in);
        sel = c;
        repeat (40) @(negedge clk_in);
        chk(sel_unsupported === (c == 4'b0101), "R4", "unsupported flag",
            longint'(sel_unsupported), longint'(c == 4'b0101));
        if (n == 0) begin
            bad = 0;
            for (int k = 0; k < 40; k++) begin
                #5;
                if (clk_main !== 1'b0 || clk_main_n !== 1'b0 || clk_half !== 1'b0) bad++;
            end
            chk(bad == 0, "R1", "power-down samples not low", bad, 0);
        end else begin
            // R6 main period and high time
            @(posedge clk_main); t0 = $realtime;
            @(negedge clk_main); t1 = $realtime;
            @(posedge clk_main); t2 = $realtime;
            chk((t1 - t0) == n * 10.0, "R6", {fam(c), " main high ns"}, longint'(t1 - t0), n * 10);
            chk((t2 - t0) == n * 20.0, "R6", {fam(c), " main period ns"}, longint'(t2 - t0), n * 20);
            // R5 half period, high time, alignment
            @(posedge clk_half); t0 = $realtime;
            #1;
            chk(clk_main === 1'b1, "R5", "main high at half rise", longint'(clk_main), 1);
            @(negedge clk_half); t1 = $realtime;
            @(posedge clk_half); t2 = $realtime;
            chk((t1 - t0) == n * 20.0, "R5", "half high ns", longint'(t1 - t0), n * 20);
            chk((t2 - t0) == n * 40.0, "R5", "half period ns", longint'(t2 - t0), n * 40);
            // R7 complement over a window
            bad = 0;
            @(negedge clk_in);
            for (int k = 0; k < 4 * n + 8; k++) begin
                #5;
                if (clk_main_n !== ~clk_main) bad++;
            end
            chk(bad == 0, "R7", "complement mismatches", bad, 0);
        end
    endtask

    initial begin
        realtime tr, tf;
        int bad;
        // R10: reset state
        repeat (3) @(posedge clk_in);
        #1;
        chk(clk_main === 1'b0 && clk_main_n === 1'b0 && clk_half === 1'b0,
            "R10", "outputs in reset", longint'({clk_main, clk_main_n, clk_half}), 0);
        chk(sel_unsupported === 1'b0, "R10", "flag in reset", longint'(sel_unsupported), 0);
        @(negedge clk_in);
        rst_n = 1'b1;

        // R1..R7 sweep over every code
        for (int c = 0; c < 16; c++) sweep_code(4'(c));

        // R9: code change in the low phase of ratio 8
        @(negedge clk_in); sel = 4'b1110;
        repeat (40) @(negedge clk_in);
        @(negedge clk_main);
        @(negedge clk_in);
        chk(clk_main === 1'b0, "R9", "main low before change", longint'(clk_main), 0);
        sel = 4'b1101;
        @(posedge clk_in); tr = $realtime;
        #1;
        chk(clk_main === 1'b1, "R9", "main rises after change", longint'(clk_main), 1);
        chk(clk_half === 1'b1, "R9", "half rises after change", longint'(clk_half), 1);
        @(negedge clk_main); tf = $realtime;
        chk((tf - tr) == 60.0, "R9", "first high pulse ns", longint'(tf - tr), 60);

        // R8: output enable low floats everything, active and power-down
        @(negedge clk_in); sel = 4'b0111; oe = 1'b0;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            #5;
            if (clk_main !== 1'bz || clk_main_n !== 1'bz || clk_half !== 1'bz) bad++;
        end
        chk(bad == 0, "R8", "not floating while active", bad, 0);
        @(negedge clk_in); sel = 4'b1000;
        bad = 0;
        for (int k = 0; k < 20; k++) begin
            #5;
            if (clk_main !== 1'bz || clk_main_n !== 1'bz || clk_half !== 1'bz) bad++;
        end
        chk(bad == 0, "R8", "not floating in power-down", bad, 0);
        @(negedge clk_in); oe = 1'b1; #1;
        chk(clk_main === 1'b0, "R8", "drives again after enable", longint'(clk_main), 0);

        // R10: reset in the middle of running
        @(negedge clk_in); sel = 4'b1011;
        repeat (10) @(negedge clk_in);
        rst_n = 1'b0;
        @(posedge clk_in); #1;
        chk(clk_main === 1'b0 && clk_main_n === 1'b0 && clk_half === 1'b0,
            "R10", "outputs after mid-run reset", longint'({clk_main, clk_main_n, clk_half}), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule